// File: doc/BRIEF.md
# MDIO Management Master

This block is a management-bus master that runs serial management transactions to external PHY devices in both the 22 and 45 clause formats of IEEE 802.3. Software reaches it through four 32-bit registers on a plain write/read port. The four registers are a configuration word, a control word holding the PHY and device/register addresses, a 16-bit extended address, and a 16-bit data word. The block divides the system clock to make MDC. It drives MDIO through an out/enable pair and samples the pad value on a separate input.

Every transaction is launched by one register access, and busy stays high until the frame is over. With the 45 format selected, writing the address register sends an address frame. A control write with its read flag set sends a read frame, and the 16 received bits land in the data register. Writing the data register sends a write frame. If no PHY pulls the second turnaround bit low during a read, an error flag is raised. Software polls busy, then checks the error flag and the data.

Register word indices are 0 configuration, 1 control, 2 address and 3 data. Configuration bits are: 0 busy (read-only), 1 read error (read-only), 2 clause-45 select, 3 edge select, and [8 +: DIV_W] divider. Control bits are: [4:0] device/register address, [9:5] PHY address, and 15 read command, which is never stored.

Top module: `mdio_master`

## Requirements
- R1: After reset every register reads 0, MDIO is not driven (enable 0) and MDC rests at 0.
- R2: While a frame runs, MDC has a period of 2*(divider+1) system clocks. Between frames MDC rests at the level of the edge-select bit.
- R3: Every frame is 64 bits sent MSB first: 32 ones, then a 2-bit start code, a 2-bit opcode, the 5-bit PHY address, the 5-bit device/register address, a 2-bit turnaround and 16 data bits. In the 22 format the start code is 01 and the opcodes are 10 for read and 01 for write.
- R4: In the 45 format the start code is 00 and the opcodes are 00 for address, 01 for write and 11 for read. Writing the address register sends an address frame that carries its 16 bits, but only when the 45 format is selected. Otherwise the write only stores the value.
- R5: Writing the data register sends a write frame with the low 16 written bits. The master drives the turnaround as 10 and drives MDIO for the whole frame.
- R6: A control write with bit 15 set sends a read frame. The master releases MDIO from the first turnaround bit to the end of the frame, and the 16 sampled bits are placed in data[15:0].
- R7: If MDIO is high when the second turnaround bit of a read is sampled, the read-error flag is set once busy clears. Starting a read or an address frame clears the flag.
- R8: Busy reads 1 from the cycle after the launching write until the frame's last bit ends. Any register write while busy is 1 has no effect.
- R9: With edge select 0, MDIO changes on the falling MDC edge and is sampled on the rising edge. With edge select 1, the two edges swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the indexed register (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the master |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO pad value |

## Verification
The bench builds the block with the default 8-bit divider field and programs divider values 0, 2 and 3 at run time. This covers the single-clock half period alongside wider ones, and lets the MDC period be measured against 2*(divider+1) with both edge selections. A behavioural PHY at one address, with a 32-entry register array, answers reads in both formats. Reads aimed at an absent address leave the line at its pulled-up level, which brings the turnaround error and its clearing within reach.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef enum logic [1:0] {FR_ADDR = 2'd0, FR_WR = 2'd1, FR_RD = 2'd2} fr_kind_e;

  localparam logic [1:0] REG_CFG  = 2'd0;
  localparam logic [1:0] REG_CTL  = 2'd1;
  localparam logic [1:0] REG_ADDR = 2'd2;
  localparam logic [1:0] REG_DATA = 2'd3;

  localparam int CFG_BUSY    = 0;
  localparam int CFG_ERR     = 1;
  localparam int CFG_C45     = 2;
  localparam int CFG_EDGE    = 3;
  localparam int CFG_DIV_LSB = 8;

  localparam int CTL_DEV_LSB = 0;
  localparam int CTL_PHY_LSB = 5;
  localparam int CTL_RD      = 15;

  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = 64;
  localparam int TA_IDX    = 46;
  localparam int DATA_IDX  = TA_IDX + 2;
  localparam int IDX_W     = $clog2(FRAME_LEN);
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sample_o,
  output logic             drive_o,
  output logic             ph_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic             tick;

  assign tick     = run_i && (cnt_q == div_i);
  assign sample_o = tick && !ph_q;  // first toggle of each period
  assign drive_o  = tick && ph_q;   // second toggle
  assign ph_o     = ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  fr_kind_e    kind_i,
  input  logic        c45_i,
  input  logic [4:0]  phy_i,
  input  logic [4:0]  dev_i,
  input  logic [15:0] payload_i,
  input  logic        sample_i,
  input  logic        drive_i,
  input  logic        mdio_i,
  output logic        busy_o,
  output logic        rd_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  output logic        done_o,
  output logic [15:0] rd_data_o,
  output logic        ta_err_o
);
  logic                 busy_q, rd_q, err_q;
  logic [FRAME_LEN-1:0] frame_q, frame_d;
  logic [IDX_W-1:0]     idx_q;
  logic [15:0]          rx_q;
  logic [1:0]           st, op, ta;
  logic [15:0]          body;

  always_comb begin
    st   = c45_i ? 2'b00 : 2'b01;
    ta   = 2'b10;
    body = payload_i;
    unique case (kind_i)
      FR_ADDR: op = 2'b00;
      FR_WR:   op = 2'b01;
      FR_RD:   op = c45_i ? 2'b11 : 2'b10;
      default: op = 2'b00;
    endcase
    if (kind_i == FR_RD) begin
      ta   = 2'b11;
      body = '1;
    end
    frame_d = {{PRE_LEN{1'b1}}, st, op, phy_i, dev_i, ta, body};
  end

  assign busy_o    = busy_q;
  assign rd_o      = rd_q;
  assign mdio_o    = frame_q[FRAME_LEN-1];
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= IDX_W'(TA_IDX));
  assign done_o    = busy_q && drive_i && (idx_q == IDX_W'(FRAME_LEN - 1));
  assign rd_data_o = rx_q;
  assign ta_err_o  = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      rd_q    <= 1'b0;
      err_q   <= 1'b0;
      frame_q <= '0;
      idx_q   <= '0;
      rx_q    <= '0;
    end else if (start_i && !busy_q) begin
      busy_q  <= 1'b1;
      rd_q    <= (kind_i == FR_RD);
      err_q   <= 1'b0;
      frame_q <= frame_d;
      idx_q   <= '0;
      rx_q    <= '0;
    end else if (busy_q) begin
      if (sample_i && rd_q) begin
        if (idx_q == IDX_W'(TA_IDX + 1)) err_q <= mdio_i;
        if (idx_q >= IDX_W'(DATA_IDX))   rx_q  <= {rx_q[14:0], mdio_i};
      end
      if (drive_i) begin
        frame_q <= frame_q << 1;
        idx_q   <= idx_q + 1'b1;
        if (idx_q == IDX_W'(FRAME_LEN - 1)) busy_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mdio_regs.sv
module mdio_regs
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic             busy_i,
  input  logic             done_i,
  input  logic             done_rd_i,
  input  logic [15:0]      rd_data_i,
  input  logic             ta_err_i,
  output logic [DIV_W-1:0] div_o,
  output logic             edge_o,
  output logic             c45_o,
  output logic             err_o,
  output logic [4:0]       phy_o,
  output logic [4:0]       dev_o,
  output logic             start_o,
  output fr_kind_e         kind_o,
  output logic [4:0]       f_phy_o,
  output logic [4:0]       f_dev_o,
  output logic [15:0]      f_payload_o
);
  logic [DIV_W-1:0] div_q;
  logic             edge_q, c45_q, err_q;
  logic [4:0]       phy_q, dev_q;
  logic [15:0]      addr_q, data_q;
  logic             acc, wr_cfg, wr_ctl, wr_adr, wr_dat, go_rd, go_adr;

  assign acc    = wr_i && !busy_i;
  assign wr_cfg = acc && addr_i == REG_CFG;
  assign wr_ctl = acc && addr_i == REG_CTL;
  assign wr_adr = acc && addr_i == REG_ADDR;
  assign wr_dat = acc && addr_i == REG_DATA;
  assign go_rd  = wr_ctl && wdata_i[CTL_RD];
  assign go_adr = wr_adr && c45_q;

  assign start_o     = go_rd || go_adr || wr_dat;
  assign kind_o      = go_rd ? FR_RD : (go_adr ? FR_ADDR : FR_WR);
  assign f_phy_o     = wr_ctl ? wdata_i[CTL_PHY_LSB +: 5] : phy_q;
  assign f_dev_o     = wr_ctl ? wdata_i[CTL_DEV_LSB +: 5] : dev_q;
  assign f_payload_o = wdata_i[15:0];

  assign div_o  = div_q;
  assign edge_o = edge_q;
  assign c45_o  = c45_q;
  assign err_o  = err_q;
  assign phy_o  = phy_q;
  assign dev_o  = dev_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      REG_CFG: begin
        rdata_o[CFG_BUSY]                = busy_i;
        rdata_o[CFG_ERR]                 = err_q;
        rdata_o[CFG_C45]                 = c45_q;
        rdata_o[CFG_EDGE]                = edge_q;
        rdata_o[CFG_DIV_LSB +: DIV_W]    = div_q;
      end
      REG_CTL: begin
        rdata_o[CTL_DEV_LSB +: 5] = dev_q;
        rdata_o[CTL_PHY_LSB +: 5] = phy_q;
      end
      REG_ADDR: rdata_o[15:0] = addr_q;
      default:  rdata_o[15:0] = data_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q  <= '0;
      edge_q <= 1'b0;
      c45_q  <= 1'b0;
      err_q  <= 1'b0;
      phy_q  <= '0;
      dev_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      if (wr_cfg) begin
        div_q  <= wdata_i[CFG_DIV_LSB +: DIV_W];
        edge_q <= wdata_i[CFG_EDGE];
        c45_q  <= wdata_i[CFG_C45];
      end
      if (wr_ctl) begin
        phy_q <= wdata_i[CTL_PHY_LSB +: 5];
        dev_q <= wdata_i[CTL_DEV_LSB +: 5];
      end
      if (wr_adr) addr_q <= wdata_i[15:0];
      if (wr_dat) data_q <= wdata_i[15:0];
      if (go_rd || go_adr) err_q <= 1'b0;
      if (done_i && done_rd_i) begin
        data_q <= rd_data_i;
        err_q  <= ta_err_i;
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [1:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  logic [DIV_W-1:0] div;
  logic             edge_sel, c45, rd_err, busy, frame_rd, done;
  logic [4:0]       phy, dev, f_phy, f_dev;
  logic [15:0]      f_payload, rd_data;
  logic             start, ta_err, sample, drive, ph;
  fr_kind_e         kind;

  mdio_regs #(.DIV_W(DIV_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .done_rd_i(frame_rd), .rd_data_i(rd_data), .ta_err_i(ta_err),
    .div_o(div), .edge_o(edge_sel), .c45_o(c45), .err_o(rd_err), .phy_o(phy), .dev_o(dev),
    .start_o(start), .kind_o(kind), .f_phy_o(f_phy), .f_dev_o(f_dev), .f_payload_o(f_payload)
  );

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i, .rst_ni, .run_i(busy), .div_i(div),
    .sample_o(sample), .drive_o(drive), .ph_o(ph)
  );

  mdio_frame u_frame (
    .clk_i, .rst_ni, .start_i(start), .kind_i(kind), .c45_i(c45),
    .phy_i(f_phy), .dev_i(f_dev), .payload_i(f_payload),
    .sample_i(sample), .drive_i(drive), .mdio_i(mdio_i),
    .busy_o(busy), .rd_o(frame_rd), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .done_o(done), .rd_data_o(rd_data), .ta_err_o(ta_err)
  );

  // Idle level follows edge select so the first toggle of a frame is always a sample edge.
  assign mdc_o = ph ^ edge_sel;
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       rd_i,
  input logic       mdc_i,
  input logic       oe_i,
  input logic       edge_i,
  input logic       err_i,
  input logic       start_i,
  input logic       start_rd_i,
  input logic       wr_i,
  input logic [4:0] phy_i,
  input logic [4:0] dev_i
);
  p_oe_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> !oe_i);
  p_mdc_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> mdc_i == edge_i);
  p_err_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_rd_i |=> !err_i);
  p_ignore_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && wr_i |=> $stable(phy_i) && $stable(dev_i) && $stable(edge_i));
  p_start_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_i |=> busy_i);
  p_write_driven_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i && !rd_i |-> oe_i);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_i(busy), .rd_i(frame_rd), .mdc_i(mdc_o),
  .oe_i(mdio_oe_o), .edge_i(edge_sel), .err_i(rd_err), .start_i(start),
  .start_rd_i(start && kind == mdio_pkg::FR_RD), .wr_i(reg_wr_i), .phy_i(phy), .dev_i(dev)
);

// File: tb/mdio_master_test.sv
module mdio_master_test;
  localparam int DIV_W = 8;
  localparam logic [4:0] PHY_AD = 5'd3;

  logic        clk = 1'b0, rst_ni = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_in;
  logic        phy_oe = 1'b0, phy_do = 1'b1;

  always #5 clk = ~clk;

  assign mdio_in = mdio_oe ? mdio_o : (phy_oe ? phy_do : 1'b1);

  mdio_master #(.DIV_W(DIV_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .mdc_o(mdc),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in)
  );

  int errors = 0, checks = 0;
  longint cyc = 0;
  always @(posedge clk) cyc++;

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // bench-side configuration and shadow of the PHY register array
  logic [DIV_W-1:0] cur_div = '0;
  logic             cur_edge = 1'b0;
  logic [15:0]      shadow [32];
  logic [15:0]      shadow_ptr = '0;
  logic [63:0]      exp_q [$];

  // ---------------- PHY model + monitor ----------------
  logic [15:0] mem [32];
  logic [15:0] ptr = '0;
  logic [63:0] cap = '0;
  logic [15:0] rd_val = '0;
  bit          phy_rd = 1'b0;
  int          nbits = 0;
  longint      t0 = 0;

  always @(posedge mdio_oe) begin
    nbits  = 0;
    phy_oe = 1'b0;
  end

  always @(mdc) begin
    if (mdc != cur_edge) begin
      int k;
      k = nbits;
      cap = {cap[62:0], mdio_in};
      if (k == 0) t0 = cyc;
      if (k == 1) check(cyc - t0 == 2 * (longint'(cur_div) + 1), "R2 mdc period", cyc - t0,
                        2 * (longint'(cur_div) + 1));
      if (k == 45) begin
        phy_rd = (cap[11:5] == {2'b10, PHY_AD} && cap[13:12] == 2'b01) ||
                 (cap[11:5] == {2'b11, PHY_AD} && cap[13:12] == 2'b00);
        rd_val = (cap[13:12] == 2'b01) ? mem[cap[4:0]] : mem[ptr[4:0]];
      end
      if (k == 46 && phy_rd) begin
        phy_oe = 1'b1;
        phy_do = 1'b0;
      end
      if (k >= 47 && k <= 62 && phy_rd) phy_do = rd_val[62 - k];
      if (k == 63) begin
        phy_oe = 1'b0;
        if (cap[27:23] == PHY_AD) begin
          if (cap[31:28] == 4'b0101) mem[cap[22:18]] = cap[15:0];
          if (cap[31:28] == 4'b0001) mem[ptr[4:0]]   = cap[15:0];
          if (cap[31:28] == 4'b0000) ptr             = cap[15:0];
        end
      end
      nbits++;
      if (nbits == 64) begin
        if (exp_q.size() == 0) check(1'b0, "R8 unexpected frame", cap, 64'h0);
        else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check(cap == e, "R3 frame bits", cap, e);
        end
      end
    end
  end

  // R9: master changes MDIO only when MDC lands on its drive edge (idle level)
  always @(mdio_o) begin
    #1;
    if (mdio_oe) check(mdc == cur_edge, "R9 drive edge", mdc, cur_edge);
  end

  // ---------------- driver ----------------
  function automatic logic [63:0] fr(bit c45, logic [1:0] op, logic [4:0] pa, logic [4:0] da,
                                     logic [1:0] ta, logic [15:0] d);
    return {32'hFFFF_FFFF, c45 ? 2'b00 : 2'b01, op, pa, da, ta, d};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(2'd0, v);
      if (!v[0]) return;
    end
    check(1'b0, "R8 busy never cleared", 1, 0);
  endtask

  task automatic set_cfg(logic [DIV_W-1:0] dv, bit edge_s, bit c45);
    cur_div  = dv;
    cur_edge = edge_s;
    wr(2'd0, (32'(dv) << 8) | (32'(edge_s) << 3) | (32'(c45) << 2));
  endtask

  task automatic do_write(bit c45, logic [4:0] pa, logic [4:0] da, logic [15:0] d);
    wr(2'd1, {22'd0, pa, da});
    exp_q.push_back(fr(c45, 2'b01, pa, da, 2'b10, d));
    wr(2'd3, {16'hDEAD, d});
    wait_idle();
    if (pa == PHY_AD) begin
      if (c45) shadow[shadow_ptr[4:0]] = d;
      else     shadow[da] = d;
    end
  endtask

  task automatic do_addr(logic [4:0] pa, logic [4:0] da, logic [15:0] a);
    wr(2'd1, {22'd0, pa, da});
    exp_q.push_back(fr(1'b1, 2'b00, pa, da, 2'b10, a));
    wr(2'd2, {16'h0, a});
    wait_idle();
    if (pa == PHY_AD) shadow_ptr = a;
  endtask

  task automatic do_read(bit c45, logic [4:0] pa, logic [4:0] da, string tag);
    logic [31:0] v;
    logic [15:0] ev;
    bit resp;
    resp = (pa == PHY_AD);
    ev   = resp ? (c45 ? shadow[shadow_ptr[4:0]] : shadow[da]) : 16'hFFFF;
    exp_q.push_back(fr(c45, c45 ? 2'b11 : 2'b10, pa, da, resp ? 2'b10 : 2'b11, ev));
    wr(2'd1, 32'h8000 | {22'd0, pa, da});
    wait_idle();
    rd(2'd3, v);
    check(v[15:0] == ev, {tag, " R6 read data"}, v[15:0], ev);
    rd(2'd0, v);
    check(v[1] == !resp, {tag, " R7 error flag"}, v[1], !resp);
  endtask

  // ---------------- sequence ----------------
  initial begin
    logic [31:0] v;
    for (int i = 0; i < 32; i++) begin
      mem[i] = 16'h0;
      shadow[i] = 16'h0;
    end
    #2 rst_ni = 1'b0;
    #20 rst_ni = 1'b1;

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v == 0, "R1 reset register", v, 0);
    end
    check(!mdio_oe && !mdc, "R1 pins idle", {mdio_oe, mdc}, 0);

    // Clause 22, divider 2, edge 0
    set_cfg(8'd2, 1'b0, 1'b0);
    do_write(1'b0, PHY_AD, 5'd5, 16'hA5C3);          // R3 R5
    do_read(1'b0, PHY_AD, 5'd5, "c22");               // R6
    do_write(1'b0, PHY_AD, 5'd31, 16'h0F01);
    do_read(1'b0, PHY_AD, 5'd31, "c22 top reg");
    do_read(1'b0, 5'd7, 5'd5, "absent phy");          // R7 error set
    do_read(1'b0, PHY_AD, 5'd5, "after error");       // R7 cleared by new read

    // R8 busy and ignored writes
    wr(2'd1, {22'd0, PHY_AD, 5'd9});
    exp_q.push_back(fr(1'b0, 2'b01, PHY_AD, 5'd9, 2'b10, 16'h1357));
    wr(2'd3, 32'h1357);
    rd(2'd0, v);
    check(v[0] == 1'b1, "R8 busy during frame", v[0], 1);
    wr(2'd1, 32'h8000 | {22'd0, 5'd12, 5'd1});
    wr(2'd3, 32'hFFFF);
    wr(2'd0, 32'h0000_0F0C);
    wait_idle();
    shadow[9] = 16'h1357;
    rd(2'd1, v);
    check(v == {22'd0, PHY_AD, 5'd9}, "R8 control kept", v, {22'd0, PHY_AD, 5'd9});
    rd(2'd0, v);
    check(v == 32'h0000_0200, "R8 config kept", v, 32'h0000_0200);
    rd(2'd3, v);
    check(v == 32'h1357, "R8 data kept", v, 32'h1357);

    // R4 address write in clause 22 sends nothing
    wr(2'd2, 32'h0042);
    rd(2'd0, v);
    check(v[0] == 1'b0, "R4 no frame in c22", v[0], 0);
    rd(2'd2, v);
    check(v == 32'h0042, "R4 address stored", v, 32'h0042);

    // Clause 45, divider 0
    set_cfg(8'd0, 1'b0, 1'b1);
    do_addr(PHY_AD, 5'd1, 16'h0007);                  // R4
    do_write(1'b1, PHY_AD, 5'd1, 16'h1234);
    do_addr(PHY_AD, 5'd1, 16'h0014);
    do_write(1'b1, PHY_AD, 5'd1, 16'hBEEF);
    do_addr(PHY_AD, 5'd1, 16'h0007);
    do_read(1'b1, PHY_AD, 5'd1, "c45");
    do_read(1'b1, 5'd9, 5'd1, "c45 absent");          // R7 error set
    do_addr(PHY_AD, 5'd1, 16'h0014);
    rd(2'd0, v);
    check(v[1] == 1'b0, "R7 cleared by address frame", v[1], 0);
    do_read(1'b1, PHY_AD, 5'd1, "c45 second");

    // R9 edge select 1, divider 3
    set_cfg(8'd3, 1'b1, 1'b0);
    repeat (2) @(negedge clk);
    check(mdc == 1'b1, "R2 R9 idle level", mdc, 1);
    do_write(1'b0, PHY_AD, 5'd17, 16'h6E91);
    do_read(1'b0, PHY_AD, 5'd17, "edge1");
    do_read(1'b0, PHY_AD, 5'd5, "edge1 old reg");

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R3 all frames seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=0", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule